// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block is the master side of a read path to a serial NOR flash. Each accepted fetch request starts one complete read transaction. The block asserts slave select and waits through a guard interval. It then clocks out a command byte and an address. An optional group of mode clocks can follow, and last it clocks in a 32-bit word. The word is returned with a one-cycle completion pulse once slave select has been released.

The command, address and data parts each choose their own number of data lines (one, two or four). Lane output enables are driven for every line the block owns, so the pad ring can build bidirectional pins. During the mode clocks, each bit carries its own enable from a mask, so some lanes can be left floating while others drive. The configuration bundle is captured when the request is accepted and held for the whole transaction.

Top module: `sfr_read_seq`

## Requirements
- R1: After reset the block is idle. busy_o and done_o are low, sck_o is low, sd_oe_o is 0, and slave select is inactive. Whenever busy_o is low, sck_o is low and sd_oe_o is 0.
- R2: Slave select is active high when sel_low_i is 0 and active low when sel_low_i is 1.
- R3: A transaction sends, in order: the command byte (MSB first, unless skip_cmd_i is 1), the address, the mode clocks (only when mode_clks_i is nonzero), and the data clocks. No other SCK cycles occur.
- R4: With addr4_i = 1, the address phase sends addr_i[31:0]. With addr4_i = 0, it sends addr_i[23:0]. In both cases the address goes MSB first.
- R5: Width codes are 0 for one line, 1 for two lines, 2 for four lines, and 3 is treated as one line. A phase runs bits/lanes SCK cycles. With L lanes, the next L bits appear on sd_o[L-1:0], and the earliest bit is on the highest lane. Command and address phases drive sd_oe_o to the L low lanes.
- R6: The mode phase lasts mode_clks_i SCK cycles at the address width. It sends mode_bits_i MSB first. Each bit is enabled by the bit of mode_oe_i at the same position. Bits past bit 0 are sent as 0 with the enable off.
- R7: During the data phase sd_oe_o is 0. sd_i is sampled at each rising SCK edge and shifted in MSB first. With one line the input is taken from sd_i[1]. With two lines it is taken from sd_i[1:0], and with four lines from sd_i[3:0].
- R8: SCK idles low. Each SCK cycle is low for sck_lo_i clocks and then high for sck_hi_i clocks. A count of 0 means 16 clocks.
- R9: The first rising SCK edge comes G + LO clocks after slave select asserts. G is 0, 2, 4 or 8 for lead code 0 to 3.
- R10: Slave select deasserts T clocks after the last falling SCK edge. T is 0, 2, 4 or 8 for trail code 0 to 3. SCK is low when slave select releases.
- R11: done_o is high for exactly one cycle. That cycle is the first cycle in which slave select is inactive again. In that cycle rdata_o holds the word read.
- R12: A request while busy_o is high is ignored. The captured configuration and address stay unchanged until done_o.
- R13: SCK is high only while slave select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request, accepted when idle |
| addr_i | input | 32 | Flash byte address |
| cmd_i | input | 8 | Read command byte |
| cmd_wd_i | input | 2 | Command lane width code |
| addr_wd_i | input | 2 | Address and mode lane width code |
| data_wd_i | input | 2 | Data lane width code |
| addr4_i | input | 1 | Four-byte address when 1 |
| skip_cmd_i | input | 1 | Skip the command phase |
| mode_clks_i | input | 4 | SCK cycles in the mode phase |
| mode_bits_i | input | 16 | Mode pattern, MSB first |
| mode_oe_i | input | 16 | Per-bit drive enable for the mode pattern |
| sel_low_i | input | 1 | Slave select active low when 1 |
| lead_i | input | 2 | Select-to-clock guard code |
| trail_i | input | 2 | Clock-to-release guard code |
| sck_hi_i | input | 4 | SCK high time in clocks, 0 = 16 |
| sck_lo_i | input | 4 | SCK low time in clocks, 0 = 16 |
| sd_i | input | 4 | Data lines from flash |
| busy_o | output | 1 | Transaction in progress |
| ss_o | output | 1 | Slave select |
| sck_o | output | 1 | Serial clock |
| sd_o | output | 4 | Data lines to flash |
| sd_oe_o | output | 4 | Per-lane output enable |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Word read |

## Verification
Some rules are checked by properties on every clock. SCK stays low outside an active select, and the block is quiet while idle. done_o lasts a single cycle and falls inside the released-select window. The captured configuration holds from acceptance to completion, and SCK is low at the moment select drops. The bench scenarios cover what needs knowledge of the whole transaction: the bit order and lane mapping of each phase, and the per-bit mode enables. They also measure the guard intervals and SCK half periods in clocks, check the assembled read word against a flash model, and confirm that a request made mid-transaction has no effect.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned ADDR3_W = 24;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MODE_W  = 16;
  localparam int unsigned SD_W    = 4;
  localparam int unsigned HALF_W  = 5;   // holds 1..16
  localparam int unsigned CYC_W   = $clog2(WORD_W) + 1;
  localparam int unsigned GRD_W   = 4;   // holds 0..8

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_CMD, ST_ADDR, ST_MODE, ST_DATA, ST_TRAIL, ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [1:0]        cmd_wd;
    logic [1:0]        addr_wd;
    logic [1:0]        data_wd;
    logic              addr4;
    logic              skip_cmd;
    logic [3:0]        mode_clks;
    logic [MODE_W-1:0] mode_bits;
    logic [MODE_W-1:0] mode_oe;
    logic              sel_low;
    logic [1:0]        lead;
    logic [1:0]        trail;
    logic [3:0]        sck_hi;
    logic [3:0]        sck_lo;
  } seq_cfg_t;

  // log2 of lane count; code 3 falls back to one line
  function automatic logic [1:0] lane_shift(logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [SD_W-1:0] lane_mask(logic [1:0] sh);
    case (sh)
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [GRD_W-1:0] guard_clks(logic [1:0] code);
    return (code == 2'd0) ? '0 : GRD_W'(1) << code;
  endfunction

  function automatic logic [HALF_W-1:0] half_clks(logic [3:0] n);
    return (n == 4'd0) ? HALF_W'(16) : HALF_W'(n);
  endfunction
endpackage

// File: rtl/sfr_sck_timer.sv
module sfr_sck_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sck_q;
  logic             last;

  assign last   = (cnt_q == CNT_W'(1));
  assign rise_o = run_i & ~sck_q & last;
  assign fall_o = run_i &  sck_q & last;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_i) begin
      sck_q <= 1'b0;
      cnt_q <= lo_i;   // preload so the first low half is exact
    end else if (last) begin
      sck_q <= ~sck_q;
      cnt_q <= sck_q ? lo_i : hi_i;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sfr_rx_capture.sv
module sfr_rx_capture #(
  parameter int unsigned W    = 32,
  parameter int unsigned SD_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            smp_i,
  input  logic [1:0]      sh_i,
  input  logic [SD_W-1:0] sd_i,
  output logic [W-1:0]    word_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (clr_i) begin
      word_q <= '0;
    end else if (smp_i) begin
      case (sh_i)
        2'd1:    word_q <= {word_q[W-3:0], sd_i[1:0]};
        2'd2:    word_q <= {word_q[W-5:0], sd_i[3:0]};
        default: word_q <= {word_q[W-2:0], sd_i[1]};
      endcase
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/sfr_read_seq.sv
module sfr_read_seq
  import sfr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [31:0] addr_i,
  input  logic [7:0]  cmd_i,
  input  logic [1:0]  cmd_wd_i,
  input  logic [1:0]  addr_wd_i,
  input  logic [1:0]  data_wd_i,
  input  logic        addr4_i,
  input  logic        skip_cmd_i,
  input  logic [3:0]  mode_clks_i,
  input  logic [15:0] mode_bits_i,
  input  logic [15:0] mode_oe_i,
  input  logic        sel_low_i,
  input  logic [1:0]  lead_i,
  input  logic [1:0]  trail_i,
  input  logic [3:0]  sck_hi_i,
  input  logic [3:0]  sck_lo_i,
  input  logic [3:0]  sd_i,
  output logic        busy_o,
  output logic        ss_o,
  output logic        sck_o,
  output logic [3:0]  sd_o,
  output logic [3:0]  sd_oe_o,
  output logic        done_o,
  output logic [31:0] rdata_o
);
  seq_cfg_t cfg_in, cfg_q, cfg_eff;
  seq_st_e  st_q, first_ph, succ_ph, ld_ph;

  logic             ss_act_q;
  logic [GRD_W-1:0] dcnt_q, lead_g, trail_g;
  logic [CYC_W-1:0] cyc_q, ld_cyc;
  logic [WORD_W-1:0] tx_q, ld_tx;
  logic [MODE_W-1:0] oe_q, ld_oe;
  logic [1:0]       sh_q, ld_sh;
  logic [2:0]       lane_cnt;
  logic             in_phase, load_now, rise, fall;

  always_comb begin
    cfg_in.addr      = addr_i;
    cfg_in.cmd       = cmd_i;
    cfg_in.cmd_wd    = cmd_wd_i;
    cfg_in.addr_wd   = addr_wd_i;
    cfg_in.data_wd   = data_wd_i;
    cfg_in.addr4     = addr4_i;
    cfg_in.skip_cmd  = skip_cmd_i;
    cfg_in.mode_clks = mode_clks_i;
    cfg_in.mode_bits = mode_bits_i;
    cfg_in.mode_oe   = mode_oe_i;
    cfg_in.sel_low   = sel_low_i;
    cfg_in.lead      = lead_i;
    cfg_in.trail     = trail_i;
    cfg_in.sck_hi    = sck_hi_i;
    cfg_in.sck_lo    = sck_lo_i;
  end

  // live inputs while idle so a zero-guard start loses no cycle
  assign cfg_eff  = (st_q == ST_IDLE) ? cfg_in : cfg_q;
  assign lead_g   = guard_clks(cfg_eff.lead);
  assign trail_g  = guard_clks(cfg_q.trail);
  assign in_phase = st_q inside {ST_CMD, ST_ADDR, ST_MODE, ST_DATA};
  assign lane_cnt = 3'd1 << sh_q;

  always_comb begin
    first_ph = cfg_eff.skip_cmd ? ST_ADDR : ST_CMD;
    case (st_q)
      ST_CMD:  succ_ph = ST_ADDR;
      ST_ADDR: succ_ph = (cfg_eff.mode_clks != 4'd0) ? ST_MODE : ST_DATA;
      ST_MODE: succ_ph = ST_DATA;
      default: succ_ph = ST_TRAIL;
    endcase
    ld_ph = (st_q inside {ST_IDLE, ST_LEAD}) ? first_ph : succ_ph;

    ld_tx  = '0;
    ld_oe  = '0;
    ld_sh  = 2'd0;
    ld_cyc = '0;
    case (ld_ph)
      ST_CMD: begin
        ld_sh  = lane_shift(cfg_eff.cmd_wd);
        ld_tx  = {cfg_eff.cmd, {(WORD_W-CMD_W){1'b0}}};
        ld_cyc = CYC_W'(CMD_W) >> ld_sh;
      end
      ST_ADDR: begin
        ld_sh  = lane_shift(cfg_eff.addr_wd);
        ld_tx  = cfg_eff.addr4 ? cfg_eff.addr
                               : {cfg_eff.addr[ADDR3_W-1:0], {(WORD_W-ADDR3_W){1'b0}}};
        ld_cyc = (cfg_eff.addr4 ? CYC_W'(ADDR_W) : CYC_W'(ADDR3_W)) >> ld_sh;
      end
      ST_MODE: begin
        ld_sh  = lane_shift(cfg_eff.addr_wd);
        ld_tx  = {cfg_eff.mode_bits, {(WORD_W-MODE_W){1'b0}}};
        ld_oe  = cfg_eff.mode_oe;
        ld_cyc = CYC_W'(cfg_eff.mode_clks);
      end
      ST_DATA: begin
        ld_sh  = lane_shift(cfg_eff.data_wd);
        ld_cyc = CYC_W'(WORD_W) >> ld_sh;
      end
      default: ;
    endcase
  end

  assign load_now = ((st_q == ST_IDLE) && req_i && (lead_g == '0))
                  || ((st_q == ST_LEAD) && (dcnt_q == GRD_W'(1)))
                  || (in_phase && fall && (cyc_q == CYC_W'(1)) && (succ_ph != ST_TRAIL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ss_act_q <= 1'b0;
      dcnt_q   <= '0;
      cfg_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          cfg_q    <= cfg_in;
          ss_act_q <= 1'b1;
          if (lead_g == '0) st_q <= ld_ph;
          else begin
            st_q   <= ST_LEAD;
            dcnt_q <= lead_g;
          end
        end
        ST_LEAD: begin
          if (dcnt_q == GRD_W'(1)) st_q <= ld_ph;
          else dcnt_q <= dcnt_q - GRD_W'(1);
        end
        ST_CMD, ST_ADDR, ST_MODE, ST_DATA: begin
          if (fall && (cyc_q == CYC_W'(1))) begin
            if (succ_ph != ST_TRAIL) st_q <= succ_ph;
            else if (trail_g == '0) begin
              ss_act_q <= 1'b0;
              st_q     <= ST_FIN;
            end else begin
              st_q   <= ST_TRAIL;
              dcnt_q <= trail_g;
            end
          end
        end
        ST_TRAIL: begin
          if (dcnt_q == GRD_W'(1)) begin
            ss_act_q <= 1'b0;
            st_q     <= ST_FIN;
          end else dcnt_q <= dcnt_q - GRD_W'(1);
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      oe_q  <= '0;
      sh_q  <= 2'd0;
      cyc_q <= '0;
    end else if (load_now) begin
      tx_q  <= ld_tx;
      oe_q  <= ld_oe;
      sh_q  <= ld_sh;
      cyc_q <= ld_cyc;
    end else if (in_phase && fall) begin
      tx_q  <= tx_q << lane_cnt;
      oe_q  <= oe_q << lane_cnt;
      cyc_q <= cyc_q - CYC_W'(1);
    end
  end

  sfr_sck_timer #(.CNT_W(HALF_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (in_phase),
    .lo_i   (half_clks(cfg_eff.sck_lo)),
    .hi_i   (half_clks(cfg_eff.sck_hi)),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sfr_rx_capture #(.W(WORD_W), .SD_W(SD_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((st_q == ST_IDLE) && req_i),
    .smp_i  ((st_q == ST_DATA) && rise),
    .sh_i   (sh_q),
    .sd_i   (sd_i),
    .word_o (rdata_o)
  );

  always_comb begin
    sd_o    = '0;
    sd_oe_o = '0;
    if (st_q inside {ST_CMD, ST_ADDR, ST_MODE}) begin
      case (sh_q)
        2'd1:    sd_o[1:0] = tx_q[WORD_W-1 -: 2];
        2'd2:    sd_o      = tx_q[WORD_W-1 -: 4];
        default: sd_o[0]   = tx_q[WORD_W-1];
      endcase
      if (st_q == ST_MODE) begin
        case (sh_q)
          2'd1:    sd_oe_o[1:0] = oe_q[MODE_W-1 -: 2];
          2'd2:    sd_oe_o      = oe_q[MODE_W-1 -: 4];
          default: sd_oe_o[0]   = oe_q[MODE_W-1];
        endcase
      end else begin
        sd_oe_o = lane_mask(sh_q);
      end
    end
  end

  assign ss_o   = cfg_eff.sel_low ? ~ss_act_q : ss_act_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);
endmodule

// File: rtl/sfr_read_seq_chk.sv
module sfr_read_seq_chk
  import sfr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_o,
  input logic       ss_act,
  input logic       busy_o,
  input logic       done_o,
  input logic [3:0] sd_oe_o,
  input seq_cfg_t   cfg_q
);
  // R13
  sck_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> ss_act);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && sd_oe_o == 4'h0));

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ss_act);

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(cfg_q));

  // R10
  sck_low_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_act) |-> !sck_o);
endmodule

bind sfr_read_seq sfr_read_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sck_o   (sck_o),
  .ss_act  (ss_act_q),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sd_oe_o (sd_oe_o),
  .cfg_q   (cfg_q)
);

// File: tb/sfr_read_seq_tb_top.sv
module sfr_read_seq_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  cmd = '0;
  logic [1:0]  cmd_wd = '0, addr_wd = '0, data_wd = '0;
  logic        addr4 = 1'b0, skip_cmd = 1'b0;
  logic [3:0]  mode_clks = '0;
  logic [15:0] mode_bits = '0, mode_oe = '0;
  logic        sel_low = 1'b1;
  logic [1:0]  lead = '0, trail = '0;
  logic [3:0]  sck_hi = 4'd1, sck_lo = 4'd1;
  logic [3:0]  sd_in = '0;
  logic        busy, ss, sck, done;
  logic [3:0]  sd_out, sd_oe;
  logic [31:0] rdata;

  sfr_read_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .cmd_i(cmd),
    .cmd_wd_i(cmd_wd), .addr_wd_i(addr_wd), .data_wd_i(data_wd),
    .addr4_i(addr4), .skip_cmd_i(skip_cmd), .mode_clks_i(mode_clks),
    .mode_bits_i(mode_bits), .mode_oe_i(mode_oe), .sel_low_i(sel_low),
    .lead_i(lead), .trail_i(trail), .sck_hi_i(sck_hi), .sck_lo_i(sck_lo),
    .sd_i(sd_in), .busy_o(busy), .ss_o(ss), .sck_o(sck), .sd_o(sd_out),
    .sd_oe_o(sd_oe), .done_o(done), .rdata_o(rdata)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] d;
    logic [3:0] oe;
    string      tag;
  } beat_t;

  typedef struct {
    int          lead;
    int          lo;
    int          hi;
    int          trail;
    logic [31:0] word;
    int          lanes;
    int          dstart;
    int          nbeats;
  } txn_t;

  beat_t beat_q[$];
  txn_t  txn_q[$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] c);
    return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
  endfunction
  function automatic int half_of(input logic [3:0] n);
    return (n == 4'd0) ? 16 : int'(n);
  endfunction
  function automatic int guard_of(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (1 << c);
  endfunction
  function automatic logic [3:0] slc(input logic [31:0] v, input int j, input int l);
    logic [31:0] s;
    s = v << (j * l);
    return 4'(s >> (32 - l));
  endfunction

  task automatic push_beat(input logic [3:0] d, input logic [3:0] oe, input string tag);
    beat_t b;
    b.d = d & oe;
    b.oe = oe;
    b.tag = tag;
    beat_q.push_back(b);
  endtask

  // driver: builds expected beats, then issues the request
  task automatic run_txn(
    input logic [7:0] c, input logic [1:0] cw, aw, dw, input logic a4, nc,
    input logic [3:0] mc, input logic [15:0] mb, mo, input logic sl,
    input logic [1:0] ld, tr, input logic [3:0] hi, lo,
    input logic [31:0] adr, input logic [31:0] word, input bit poke);
    txn_t t;
    int l, n;
    logic [31:0] v;
    n = 0;
    if (!nc) begin
      l = lanes_of(cw);
      for (int j = 0; j < 8 / l; j++) push_beat(slc({c, 24'h0}, j, l), 4'((1 << l) - 1), "R3 cmd");
      n += 8 / l;
    end
    l = lanes_of(aw);
    v = a4 ? adr : {adr[23:0], 8'h0};
    for (int j = 0; j < (a4 ? 32 : 24) / l; j++) push_beat(slc(v, j, l), 4'((1 << l) - 1), "R4 addr");
    n += (a4 ? 32 : 24) / l;
    for (int j = 0; j < int'(mc); j++) push_beat(slc({mb, 16'h0}, j, l), slc({mo, 16'h0}, j, l), "R6 mode");
    n += int'(mc);
    t.dstart = n;
    l = lanes_of(dw);
    for (int j = 0; j < 32 / l; j++) push_beat(4'h0, 4'h0, "R7 data");
    n += 32 / l;
    t.lanes = l;
    t.nbeats = n;
    t.lo = half_of(lo);
    t.hi = half_of(hi);
    t.lead = guard_of(ld) + t.lo;
    t.trail = guard_of(tr);
    t.word = word;
    txn_q.push_back(t);

    @(negedge clk);
    cmd = c; cmd_wd = cw; addr_wd = aw; data_wd = dw; addr4 = a4; skip_cmd = nc;
    mode_clks = mc; mode_bits = mb; mode_oe = mo; sel_low = sl; lead = ld; trail = tr;
    sck_hi = hi; sck_lo = lo; addr = adr; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (15) @(negedge clk);
      addr = ~adr; cmd = ~c; mode_bits = ~mb; req = 1'b1;   // R12 ignored request
      @(negedge clk);
      req = 1'b0;
    end
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
  endtask

  // monitor and flash model
  initial begin : mon
    int t, t_ss, t_rise, t_fall, rises;
    bit prev_sck, prev_ss, in_txn, ss_act;
    txn_t cur;
    beat_t b;
    t = 0; t_ss = 0; t_rise = 0; t_fall = 0; rises = 0;
    prev_sck = 1'b0; prev_ss = 1'b0; in_txn = 1'b0;
    @(posedge rst_ni);
    forever begin
      @(posedge clk);
      #3;
      t++;
      ss_act = sel_low ? ~ss : ss;
      if (ss_act && !prev_ss) begin
        if (txn_q.size() == 0) chk("R12 unexpected transaction", 32'd1, 32'd0);
        else begin
          cur = txn_q.pop_front();
          in_txn = 1'b1;
          t_ss = t;
          rises = 0;
        end
      end
      if (sck && !prev_sck) begin
        if (rises == 0) chk("R9 select to first rise", 32'(t - t_ss), 32'(cur.lead));
        else chk("R8 rise to rise", 32'(t - t_rise), 32'(cur.lo + cur.hi));
        t_rise = t;
        if (beat_q.size() == 0) chk("R3 extra SCK cycle", 32'd1, 32'd0);
        else begin
          b = beat_q.pop_front();
          chk({b.tag, " /R5 lane enables"}, 32'(sd_oe), 32'(b.oe));
          chk({b.tag, " bits"}, 32'(sd_out & b.oe), 32'(b.d));
        end
        rises++;
      end
      if (!sck && prev_sck) begin
        chk("R8 high time", 32'(t - t_rise), 32'(cur.hi));
        t_fall = t;
      end
      if (!ss_act && prev_ss && in_txn) begin
        chk("R10 last fall to release", 32'(t - t_fall), 32'(cur.trail));
        chk("R11 done at release", 32'(done), 32'd1);
        chk("R7 read word", rdata, cur.word);
        chk("R3 SCK cycle count", 32'(rises), 32'(cur.nbeats));
        in_txn = 1'b0;
      end
      if (in_txn && rises >= cur.dstart && rises < cur.nbeats) begin
        logic [3:0] bits;
        bits = slc(cur.word, rises - cur.dstart, cur.lanes);
        case (cur.lanes)
          1:       sd_in = {~bits[0], ~bits[0], bits[0], ~bits[0]};
          2:       sd_in = {~bits[1:0], bits[1:0]};
          default: sd_in = bits;
        endcase
      end else begin
        sd_in = 4'h5;
      end
      prev_sck = sck;
      prev_ss = ss_act;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 sck after reset", 32'(sck), 32'd0);
    chk("R1 oe after reset", 32'(sd_oe), 32'd0);
    chk("R2 idle select active-low", 32'(ss), 32'd1);
    sel_low = 1'b0;
    #1;
    chk("R2 idle select active-high", 32'(ss), 32'd0);
    sel_low = 1'b1;

    // single line, 3-byte address, no mode
    run_txn(8'h03, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 1'b1,
            2'd0, 2'd0, 4'd2, 4'd2, 32'h0012_3456, 32'hDEAD_BEEF, 1'b0);
    // quad address and data, two mode clocks
    run_txn(8'hEB, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd2, 16'hA5C3, 16'hFF00, 1'b1,
            2'd1, 2'd2, 4'd1, 4'd3, 32'h00AB_CDEF, 32'h1357_9BDF, 1'b0);
    // dual everywhere, 4-byte, active-high select, high time code 0 = 16
    run_txn(8'hBB, 2'd1, 2'd1, 2'd1, 1'b1, 1'b0, 4'd3, 16'h9C00, 16'hB400, 1'b0,
            2'd3, 2'd3, 4'd0, 4'd1, 32'hF0E1_D2C3, 32'h2468_ACE0, 1'b0);
    chk("R2 released level active-high", 32'(ss), 32'd0);
    // command skipped, width code 3 as one line, mode past pattern end
    run_txn(8'hFF, 2'd0, 2'd3, 2'd2, 1'b1, 1'b1, 4'd5, 16'hB000, 16'hA800, 1'b1,
            2'd2, 2'd1, 4'd1, 4'd1, 32'h8000_0001, 32'hC0FF_EE11, 1'b0);
    // quad command, one-line data via code 3, request while busy
    run_txn(8'h6B, 2'd2, 2'd3, 2'd3, 1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 1'b1,
            2'd0, 2'd0, 4'd1, 4'd1, 32'h00FF_FFFF, 32'h0F0F_5AA5, 1'b1);
    // mode longer than pattern at quad width
    run_txn(8'h0B, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd6, 16'h1234, 16'hFFFF, 1'b1,
            2'd0, 2'd3, 4'd3, 4'd0, 32'h0055_AA00, 32'h8421_7BDE, 1'b0);

    repeat (20) @(negedge clk);
    chk("R12 no stray transaction", 32'(txn_q.size()), 32'd0);
    chk("R3 all beats consumed", 32'(beat_q.size()), 32'd0);
    chk("R1 idle at end", 32'(busy), 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule